// File: doc/BRIEF.md
# Pointer Address Generator with Embedded Register File

This block forms the 16-bit data address for every load and store of a small 8-bit load-store core. It contains the core's 32-entry, 8-bit register file. The top three register pairs double as 16-bit pointers, so a pointer update is a two-byte write into that same file. An access names an addressing mode, a pointer, a 6-bit displacement, an absolute address, a direction and a data register. In the same cycle the block drives the effective address, a region code and, for memory-side traffic, the strobe, write enable and store data.

Addresses below 32 do not reach memory. They land on the register file: a load copies one register into another, and a store writes a register. The next 64 addresses form the I/O window. The block gives the window index alongside the address. Everything above that goes to SRAM, whose load data returns combinationally on `mem_rdata`. Writes caused by an access, the pointer update and the load result all take effect on the clock edge that ends the access. A separate write port lets the rest of the core update registers. A read port lets it observe them.

Top module: `ptr_agu`

## Requirements
- R1: After reset every one of the 32 registers reads 0 on `rf_rdata`.
- R2: Pointer code 0 selects the pair r27:r26, code 1 selects r29:r28 and code 2 selects r31:r30, with the odd register as the high byte. Mode 1 (plain indirect) uses the pointer as the address and leaves it unchanged.
- R3: Mode 0 (absolute) uses `acc_direct` as the address, ignores the pointer code and changes no pointer.
- R4: Mode 2 adds the zero-extended 6-bit displacement to pointer 1 or 2 and leaves the pointer unchanged. Mode 2 with pointer 0, any pointer mode with pointer code 3, and mode codes 5 to 7 all raise `acc_fault`. A faulting access drives `mem_valid` low and writes no register.
- R5: Mode 3 lowers the pointer by one, uses the lowered value as the address and writes it back at the edge. The borrow crosses the byte boundary, so 0x0100 becomes 0x00FF.
- R6: Mode 4 uses the old pointer as the address and writes back the pointer plus one at the edge. The carry crosses bytes (0x00FF becomes 0x0100), and 0xFFFF wraps to 0x0000.
- R7: `mem_region` is 0 for addresses 0x0000 to 0x001F, 1 for 0x0020 to 0x005F and 2 above that. In region 1, `mem_io_idx` equals the address minus 0x20.
- R8: In region 0 `mem_valid` stays low. A load copies the register numbered by address bits 4:0 into `acc_reg`. A store writes `acc_reg`'s value into that register.
- R9: In regions 1 and 2 `mem_valid` is high and `mem_we` equals `acc_store`. A store drives `mem_wdata` with register `acc_reg`. A load writes `mem_rdata` into `acc_reg` at the edge.
- R10: `rf_we` writes `rf_wdata` into register `rf_waddr` at the edge. It is ignored in any cycle where an accepted access writes a single register (any load, or a region-0 store). A pointer update overrides it on the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| acc_valid | input | 1 | An access is requested this cycle |
| acc_mode | input | 3 | Addressing mode code |
| acc_ptr | input | 2 | Pointer pair select |
| acc_disp | input | 6 | Displacement for mode 2 |
| acc_direct | input | 16 | Absolute address for mode 0 |
| acc_store | input | 1 | 1 for store, 0 for load |
| acc_reg | input | 5 | Data register (source or destination) |
| acc_fault | output | 1 | Request is illegal and suppressed |
| mem_valid | output | 1 | Memory-side access strobe |
| mem_we | output | 1 | Memory-side write enable |
| mem_addr | output | 16 | Effective address |
| mem_region | output | 2 | Region code of the address |
| mem_io_idx | output | 6 | I/O window index |
| mem_wdata | output | 8 | Store data |
| mem_rdata | input | 8 | Load data from I/O or SRAM |
| rf_we | input | 1 | Register write strobe |
| rf_waddr | input | 5 | Register write index |
| rf_wdata | input | 8 | Register write data |
| rf_raddr | input | 5 | Register observe index |
| rf_rdata | output | 8 | Register observe data |

## Verification
The bench builds the block with its default parameters: 32 registers of 8 bits, a 6-bit displacement and a 64-entry I/O window. With these values the byte-carry and byte-borrow points (0x00FF/0x0100), the full-width wrap at 0xFFFF, the largest displacement of 63 and both edges of each region (0x1F/0x20 and 0x5F/0x60) can all be reached directly by small, directed pointer values. Random traffic keeps pointer high bytes near zero half of the time, so that register-window and I/O-window accesses occur often, and it interleaves write-port traffic with accesses to exercise the write priority.

// File: rtl/agu_pkg.sv
package agu_pkg;

    typedef enum logic [2:0] {
        AM_ABS     = 3'd0,
        AM_IND     = 3'd1,
        AM_DISP    = 3'd2,
        AM_PREDEC  = 3'd3,
        AM_POSTINC = 3'd4
    } amode_e;

    typedef enum logic [1:0] {
        RG_REGS = 2'd0,
        RG_IO   = 2'd1,
        RG_SRAM = 2'd2
    } region_e;

    localparam logic [1:0] PSEL_LO  = 2'd0;
    localparam int         NUM_PTRS = 3;

endpackage

// File: rtl/agu_regfile.sv
module agu_regfile #(
    parameter int NREGS  = 32,
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(NREGS),
    localparam int PTR_W = 2 * DATA_W
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  byte_we,
    input  logic [IDX_W-1:0]                      byte_waddr,
    input  logic [DATA_W-1:0]                     byte_wdata,
    input  logic                                  pair_we,
    input  logic [1:0]                            pair_sel,
    input  logic [PTR_W-1:0]                      pair_wdata,
    input  logic [IDX_W-1:0]                      rd_a_idx,
    output logic [DATA_W-1:0]                     rd_a_data,
    input  logic [IDX_W-1:0]                      rd_b_idx,
    output logic [DATA_W-1:0]                     rd_b_data,
    input  logic [IDX_W-1:0]                      rd_c_idx,
    output logic [DATA_W-1:0]                     rd_c_data,
    output logic [agu_pkg::NUM_PTRS-1:0][PTR_W-1:0] ptrs
);
    import agu_pkg::*;

    localparam int PTR_BASE = NREGS - 2 * NUM_PTRS;

    typedef struct packed {
        logic [NREGS-1:0][DATA_W-1:0] regs;
    } rf_state_t;

    rf_state_t st_d, st_q;

    // Next state: single byte first, pointer pair last so that it wins.
    always_comb begin
        st_d = st_q;
        if (byte_we) begin
            st_d.regs[byte_waddr] = byte_wdata;
        end
        for (int k = 0; k < NUM_PTRS; k++) begin
            if (pair_we && pair_sel == 2'(k)) begin
                st_d.regs[PTR_BASE + 2*k]     = pair_wdata[DATA_W-1:0];
                st_d.regs[PTR_BASE + 2*k + 1] = pair_wdata[PTR_W-1:DATA_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_a_data = st_q.regs[rd_a_idx];
    assign rd_b_data = st_q.regs[rd_b_idx];
    assign rd_c_data = st_q.regs[rd_c_idx];

    for (genvar g = 0; g < NUM_PTRS; g++) begin : g_ptr
        assign ptrs[g] = {st_q.regs[PTR_BASE + 2*g + 1], st_q.regs[PTR_BASE + 2*g]};
    end

    // Whether the single-byte write lands inside the pair being updated.
    logic byte_in_pair;
    assign byte_in_pair = pair_we && (pair_sel != 2'd3) &&
                          (byte_waddr[IDX_W-1:1] ==
                           ((IDX_W-1)'(PTR_BASE / 2) + (IDX_W-1)'(pair_sel)));

    // R6 / R5: a pointer update shows up as the new 16-bit pointer value.
    p_pair_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_we && pair_sel != 2'd3) |=> ptrs[$past(pair_sel)] == $past(pair_wdata));

    // R10: a byte write outside the updated pair is visible on the next cycle.
    p_byte_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_we && !byte_in_pair) |=> st_q.regs[$past(byte_waddr)] == $past(byte_wdata));

endmodule

// File: rtl/agu_addr_gen.sv
module agu_addr_gen #(
    parameter int PTR_W  = 16,
    parameter int DISP_W = 6
) (
    input  logic [2:0]                              mode,
    input  logic [1:0]                              sel,
    input  logic [DISP_W-1:0]                       disp,
    input  logic [PTR_W-1:0]                        direct,
    input  logic [agu_pkg::NUM_PTRS-1:0][PTR_W-1:0] ptrs,
    output logic [PTR_W-1:0]                        eff_addr,
    output logic                                    fault,
    output logic                                    upd_en,
    output logic [PTR_W-1:0]                        upd_value
);
    import agu_pkg::*;

    logic             bad_sel;
    logic [PTR_W-1:0] base;
    logic [PTR_W-1:0] base_dec;
    logic [PTR_W-1:0] base_inc;

    assign bad_sel  = (sel == 2'd3);
    assign base     = bad_sel ? '0 : ptrs[sel];
    assign base_dec = base - PTR_W'(1);
    assign base_inc = base + PTR_W'(1);

    always_comb begin
        eff_addr  = direct;
        fault     = 1'b0;
        upd_en    = 1'b0;
        upd_value = base;
        case (mode)
            AM_ABS: begin
                eff_addr = direct;
            end
            AM_IND: begin
                eff_addr = base;
                fault    = bad_sel;
            end
            AM_DISP: begin
                eff_addr = base + PTR_W'(disp);
                fault    = bad_sel || (sel == PSEL_LO);
            end
            AM_PREDEC: begin
                eff_addr  = base_dec;
                fault     = bad_sel;
                upd_en    = 1'b1;
                upd_value = base_dec;
            end
            AM_POSTINC: begin
                eff_addr  = base;
                fault     = bad_sel;
                upd_en    = 1'b1;
                upd_value = base_inc;
            end
            default: begin
                fault = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/agu_region.sv
module agu_region #(
    parameter int ADDR_W   = 16,
    parameter int NREGS    = 32,
    parameter int IO_COUNT = 64,
    localparam int IO_IDX_W = $clog2(IO_COUNT)
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [1:0]          region,
    output logic [IO_IDX_W-1:0] io_idx
);
    import agu_pkg::*;

    localparam logic [ADDR_W-1:0] IO_LO = ADDR_W'(NREGS);
    localparam logic [ADDR_W-1:0] IO_HI = ADDR_W'(NREGS + IO_COUNT);

    logic [ADDR_W-1:0] io_off;
    assign io_off = addr - IO_LO;

    always_comb begin
        if (addr < IO_LO) begin
            region = RG_REGS;
        end else if (addr < IO_HI) begin
            region = RG_IO;
        end else begin
            region = RG_SRAM;
        end
        io_idx = io_off[IO_IDX_W-1:0];
    end

endmodule

// File: rtl/ptr_agu.sv
module ptr_agu #(
    parameter int NREGS    = 32,
    parameter int DATA_W   = 8,
    parameter int DISP_W   = 6,
    parameter int IO_COUNT = 64,
    localparam int PTR_W    = 2 * DATA_W,
    localparam int IDX_W    = $clog2(NREGS),
    localparam int IO_IDX_W = $clog2(IO_COUNT)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_valid,
    input  logic [2:0]          acc_mode,
    input  logic [1:0]          acc_ptr,
    input  logic [DISP_W-1:0]   acc_disp,
    input  logic [PTR_W-1:0]    acc_direct,
    input  logic                acc_store,
    input  logic [IDX_W-1:0]    acc_reg,
    output logic                acc_fault,
    output logic                mem_valid,
    output logic                mem_we,
    output logic [PTR_W-1:0]    mem_addr,
    output logic [1:0]          mem_region,
    output logic [IO_IDX_W-1:0] mem_io_idx,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic [DATA_W-1:0]   mem_rdata,
    input  logic                rf_we,
    input  logic [IDX_W-1:0]    rf_waddr,
    input  logic [DATA_W-1:0]   rf_wdata,
    input  logic [IDX_W-1:0]    rf_raddr,
    output logic [DATA_W-1:0]   rf_rdata
);
    import agu_pkg::*;

    logic [NUM_PTRS-1:0][PTR_W-1:0] ptrs;
    logic [PTR_W-1:0]  eff_addr;
    logic [PTR_W-1:0]  upd_value;
    logic              gen_fault;
    logic              upd_en;
    logic [1:0]        region;
    logic [DATA_W-1:0] src_data;
    logic [DATA_W-1:0] win_data;

    logic              take;
    logic              win_hit;
    logic              byte_we;
    logic [IDX_W-1:0]  byte_waddr;
    logic [DATA_W-1:0] byte_wdata;
    logic              pair_we;

    agu_addr_gen #(.PTR_W(PTR_W), .DISP_W(DISP_W)) u_gen (
        .mode      (acc_mode),
        .sel       (acc_ptr),
        .disp      (acc_disp),
        .direct    (acc_direct),
        .ptrs      (ptrs),
        .eff_addr  (eff_addr),
        .fault     (gen_fault),
        .upd_en    (upd_en),
        .upd_value (upd_value)
    );

    agu_region #(.ADDR_W(PTR_W), .NREGS(NREGS), .IO_COUNT(IO_COUNT)) u_region (
        .addr   (eff_addr),
        .region (region),
        .io_idx (mem_io_idx)
    );

    agu_regfile #(.NREGS(NREGS), .DATA_W(DATA_W)) u_rf (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_we    (byte_we),
        .byte_waddr (byte_waddr),
        .byte_wdata (byte_wdata),
        .pair_we    (pair_we),
        .pair_sel   (acc_ptr),
        .pair_wdata (upd_value),
        .rd_a_idx   (acc_reg),
        .rd_a_data  (src_data),
        .rd_b_idx   (eff_addr[IDX_W-1:0]),
        .rd_b_data  (win_data),
        .rd_c_idx   (rf_raddr),
        .rd_c_data  (rf_rdata),
        .ptrs       (ptrs)
    );

    assign take    = acc_valid && !gen_fault;
    assign win_hit = (region == RG_REGS);

    // Write-port selection: an access that writes a byte beats the side port.
    always_comb begin
        byte_we    = 1'b0;
        byte_waddr = rf_waddr;
        byte_wdata = rf_wdata;
        if (take && acc_store && win_hit) begin
            byte_we    = 1'b1;
            byte_waddr = eff_addr[IDX_W-1:0];
            byte_wdata = src_data;
        end else if (take && !acc_store) begin
            byte_we    = 1'b1;
            byte_waddr = acc_reg;
            byte_wdata = win_hit ? win_data : mem_rdata;
        end else if (rf_we) begin
            byte_we    = 1'b1;
        end
        pair_we = take && upd_en;
    end

    assign acc_fault  = acc_valid && gen_fault;
    assign mem_valid  = take && !win_hit;
    assign mem_we     = mem_valid && acc_store;
    assign mem_addr   = eff_addr;
    assign mem_region = region;
    assign mem_wdata  = src_data;

    // R4: a refused request never reaches memory.
    p_fault_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        acc_fault |-> !mem_valid);

    // R8 / R9: the memory strobe never covers the register window.
    p_no_window_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (mem_region != RG_REGS));

    // R7: the I/O code only appears inside the I/O window.
    p_io_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_region == RG_IO) |->
            (mem_addr >= PTR_W'(NREGS) && mem_addr < PTR_W'(NREGS + IO_COUNT)));

    // R6: post-increment addresses with the stored pointer.
    p_postinc_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_fault && acc_mode == AM_POSTINC) |-> mem_addr == ptrs[acc_ptr]);

    // R5: after pre-decrement the pointer equals the address that was used.
    p_predec_wb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_fault && acc_mode == AM_PREDEC) |=>
            ptrs[$past(acc_ptr)] == $past(mem_addr));

endmodule

// File: tb/ptr_agu_tb_top.sv
`timescale 1ns/1ps
module ptr_agu_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [2:0]  acc_mode = '0;
    logic [1:0]  acc_ptr = '0;
    logic [5:0]  acc_disp = '0;
    logic [15:0] acc_direct = '0;
    logic        acc_store = 1'b0;
    logic [4:0]  acc_reg = '0;
    logic        acc_fault;
    logic        mem_valid, mem_we;
    logic [15:0] mem_addr;
    logic [1:0]  mem_region;
    logic [5:0]  mem_io_idx;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        rf_we = 1'b0;
    logic [4:0]  rf_waddr = '0;
    logic [7:0]  rf_wdata = '0;
    logic [4:0]  rf_raddr = '0;
    logic [7:0]  rf_rdata;

    always #4 clk = ~clk;

    function automatic logic [7:0] mem_fn(input logic [15:0] a);
        return {a[3:0], a[7:4]} ^ a[15:8] ^ 8'hA5;
    endfunction

    assign mem_rdata = mem_fn(mem_addr);

    ptr_agu dut_i (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_mode(acc_mode), .acc_ptr(acc_ptr),
        .acc_disp(acc_disp), .acc_direct(acc_direct), .acc_store(acc_store),
        .acc_reg(acc_reg), .acc_fault(acc_fault),
        .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_region(mem_region), .mem_io_idx(mem_io_idx),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .rf_raddr(rf_raddr), .rf_rdata(rf_rdata)
    );

    logic [7:0] m [32];
    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] ptr_of(input logic [1:0] ps);
        if (ps == 2'd3) return 16'h0;
        return {m[27 + 2*ps], m[26 + 2*ps]};
    endfunction

    task automatic ext_wr(input logic [4:0] i, input logic [7:0] d);
        @(negedge clk);
        rf_we = 1'b1; rf_waddr = i; rf_wdata = d;
        @(posedge clk);
        m[i] = d;
        #1 rf_we = 1'b0;
    endtask

    task automatic set_ptr(input logic [1:0] ps, input logic [15:0] v);
        ext_wr(5'(26 + 2*ps), v[7:0]);
        ext_wr(5'(27 + 2*ps), v[15:8]);
    endtask

    task automatic chk_reg(input logic [4:0] i, input string req);
        @(negedge clk);
        rf_raddr = i;
        #1 chk(rf_rdata === m[i], req, $sformatf("reg r%0d", i), rf_rdata, m[i]);
    endtask

    task automatic chk_ptr(input logic [1:0] ps, input logic [15:0] v, input string req);
        logic [15:0] got;
        @(negedge clk);
        rf_raddr = 5'(26 + 2*ps);
        #1 got[7:0] = rf_rdata;
        rf_raddr = 5'(27 + 2*ps);
        #1 got[15:8] = rf_rdata;
        chk(got === v, req, "pointer", got, v);
    endtask

    task automatic sweep(input string req);
        for (int i = 0; i < 32; i++) chk_reg(5'(i), req);
    endtask

    task automatic acc(input logic [2:0] md, input logic [1:0] ps, input logic [5:0] q,
                       input logic [15:0] dir, input bit st, input logic [4:0] rg,
                       input bit xe, input logic [4:0] xi, input logic [7:0] xd,
                       input string req);
        logic [15:0] p, ea, np;
        bit flt, upd, bw;
        logic [1:0] rexp;
        logic [7:0] bv;
        logic [4:0] bi;
        p = ptr_of(ps);
        flt = (md > 3'd4) || (md != 3'd0 && ps == 2'd3) || (md == 3'd2 && ps == 2'd0);
        upd = (md == 3'd3) || (md == 3'd4);
        case (md)
            3'd0: ea = dir;
            3'd2: ea = p + {10'h0, q};
            3'd3: ea = p - 16'd1;
            default: ea = p;
        endcase
        np = (md == 3'd3) ? p - 16'd1 : p + 16'd1;
        rexp = (ea < 16'h20) ? 2'd0 : (ea < 16'h60) ? 2'd1 : 2'd2;
        @(negedge clk);
        acc_valid = 1'b1; acc_mode = md; acc_ptr = ps; acc_disp = q;
        acc_direct = dir; acc_store = st; acc_reg = rg;
        rf_we = xe; rf_waddr = xi; rf_wdata = xd;
        #1;
        chk(acc_fault === flt, flt ? "R4" : req, "fault", acc_fault, flt);
        if (!flt) begin
            chk(mem_addr === ea, req, "address", mem_addr, ea);
            chk(mem_region === rexp, "R7", "region", mem_region, rexp);
            chk(mem_valid === (rexp != 2'd0), (rexp == 0) ? "R8" : "R9", "strobe",
                mem_valid, rexp != 2'd0);
            if (rexp != 2'd0) chk(mem_we === st, "R9", "write enable", mem_we, st);
            if (rexp != 2'd0 && st) chk(mem_wdata === m[rg], "R9", "store data", mem_wdata, m[rg]);
            if (rexp == 2'd1) chk(mem_io_idx === 6'(ea - 16'h20), "R7", "io index",
                                  mem_io_idx, 6'(ea - 16'h20));
        end else begin
            chk(mem_valid === 1'b0, "R4", "strobe on fault", mem_valid, 0);
        end
        @(posedge clk);
        bw = 1'b0; bi = '0; bv = '0;
        if (!flt && !st) begin
            bw = 1'b1; bi = rg; bv = (rexp == 2'd0) ? m[ea[4:0]] : mem_fn(ea);
        end else if (!flt && st && rexp == 2'd0) begin
            bw = 1'b1; bi = ea[4:0]; bv = m[rg];
        end
        if (bw) m[bi] = bv;
        else if (xe) m[xi] = xd;
        if (!flt && upd) begin
            m[26 + 2*ps] = np[7:0];
            m[27 + 2*ps] = np[15:8];
        end
        #1;
        acc_valid = 1'b0; rf_we = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 32; i++) m[i] = 8'h00;
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset contents
        sweep("R1");
        chk(mem_valid === 1'b0, "R1", "idle strobe", mem_valid, 0);

        // R10: side-port writes; set up pointers
        for (int i = 0; i < 26; i++) ext_wr(5'(i), 8'(i * 7 + 3));
        set_ptr(2'd0, 16'h00FF);
        set_ptr(2'd1, 16'h0100);
        set_ptr(2'd2, 16'hFFFF);
        sweep("R10");

        // R6: carry across bytes, and full wrap
        acc(3'd4, 2'd0, 6'd0, 16'h0, 1'b0, 5'd4, 1'b0, 5'd0, 8'd0, "R6");
        chk_ptr(2'd0, 16'h0100, "R6");
        acc(3'd4, 2'd2, 6'd0, 16'h0, 1'b1, 5'd5, 1'b0, 5'd0, 8'd0, "R6");
        chk_ptr(2'd2, 16'h0000, "R6");
        // R5: borrow across bytes
        acc(3'd3, 2'd1, 6'd0, 16'h0, 1'b1, 5'd6, 1'b0, 5'd0, 8'd0, "R5");
        chk_ptr(2'd1, 16'h00FF, "R5");
        // R4: illegal combinations leave everything untouched
        acc(3'd2, 2'd0, 6'd5, 16'h0, 1'b0, 5'd7, 1'b0, 5'd0, 8'd0, "R4");
        acc(3'd5, 2'd1, 6'd0, 16'h0, 1'b0, 5'd7, 1'b0, 5'd0, 8'd0, "R4");
        acc(3'd4, 2'd3, 6'd0, 16'h0, 1'b0, 5'd7, 1'b0, 5'd0, 8'd0, "R4");
        chk_reg(5'd7, "R4");
        chk_ptr(2'd0, 16'h0100, "R4");
        chk_ptr(2'd1, 16'h00FF, "R4");
        // R4: largest displacement, pointer unchanged
        set_ptr(2'd2, 16'h0020);
        acc(3'd2, 2'd2, 6'd63, 16'h0, 1'b0, 5'd8, 1'b0, 5'd0, 8'd0, "R4");
        chk_ptr(2'd2, 16'h0020, "R4");
        // R8: register window through displacement
        set_ptr(2'd1, 16'h0010);
        acc(3'd2, 2'd1, 6'd15, 16'h0, 1'b0, 5'd9, 1'b0, 5'd0, 8'd0, "R8");
        acc(3'd2, 2'd1, 6'd2, 16'h0, 1'b1, 5'd3, 1'b0, 5'd0, 8'd0, "R8");
        chk_reg(5'd9, "R8");
        chk_reg(5'd18, "R8");
        // R3 / R7: absolute addresses at the region edges
        acc(3'd0, 2'd3, 6'd0, 16'h001F, 1'b0, 5'd10, 1'b0, 5'd0, 8'd0, "R3");
        acc(3'd0, 2'd0, 6'd0, 16'h0020, 1'b1, 5'd10, 1'b0, 5'd0, 8'd0, "R3");
        acc(3'd0, 2'd0, 6'd0, 16'h005F, 1'b0, 5'd11, 1'b0, 5'd0, 8'd0, "R3");
        acc(3'd0, 2'd0, 6'd0, 16'h0060, 1'b0, 5'd12, 1'b0, 5'd0, 8'd0, "R3");
        // R2: plain indirect keeps the pointer
        acc(3'd1, 2'd0, 6'd0, 16'h0, 1'b0, 5'd13, 1'b0, 5'd0, 8'd0, "R2");
        chk_ptr(2'd0, 16'h0100, "R2");
        // R10: side port loses to a load, applies alongside an SRAM store
        acc(3'd1, 2'd0, 6'd0, 16'h0, 1'b0, 5'd14, 1'b1, 5'd15, 8'hEE, "R10");
        chk_reg(5'd15, "R10");
        acc(3'd1, 2'd0, 6'd0, 16'h0, 1'b1, 5'd14, 1'b1, 5'd16, 8'hDD, "R10");
        chk_reg(5'd16, "R10");
        sweep("R9");

        // Random traffic
        for (int n = 0; n < 1500; n++) begin
            logic [2:0] md; logic [1:0] ps; logic [4:0] rg, xi;
            logic [15:0] dir, p, ea; bit st, xe; logic [7:0] xd;
            if ($urandom_range(0, 3) == 0) begin
                xi = 5'($urandom_range(0, 31));
                xd = 8'($urandom);
                if (xi >= 26 && xi[0] && $urandom_range(0, 1) == 1) xd = 8'h00;
                ext_wr(xi, xd);
            end else begin
                md = 3'($urandom_range(0, 5));
                ps = 2'($urandom_range(0, 3));
                rg = 5'($urandom);
                st = 1'($urandom);
                dir = ($urandom_range(0, 1) == 1) ? 16'($urandom_range(0, 127)) : 16'($urandom);
                xe = ($urandom_range(0, 3) == 0);
                xi = 5'($urandom); xd = 8'($urandom);
                if (ps == 2'd3 && $urandom_range(0, 3) != 0) ps = 2'd1;
                if ((md == 3'd3 || md == 3'd4) && ps != 2'd3) begin
                    p = ptr_of(ps);
                    ea = (md == 3'd3) ? p - 16'd1 : p;
                    if (!st && rg[4:1] == 4'(13 + ps)) rg = rg ^ 5'h08;
                    if (ea < 16'h20 && ea[4:1] == 4'(13 + ps)) md = 3'd1;
                end
                acc(md, ps, 6'($urandom), dir, st, rg, xe, xi, xd,
                    (md == 3'd0) ? "R3" : (md == 3'd3) ? "R5" : (md == 3'd4) ? "R6" :
                    (md == 3'd2) ? "R4" : "R2");
            end
        end
        sweep("R10");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule